// File: doc/BRIEF.md
# Cyclic Memory Cycle Sequencer With Parity

This block drives a memory port through a fixed schedule of twelve timing pulses per cycle. There is no idle state: each cycle starts again as soon as the last one ends. Each cycle does four things in order. It latches a requested address and an erasable/fixed flag. It reads the addressed 16-bit word into a buffer register. It opens a four-pulse window in which the processor may read or change the 15 data bits of that buffer. It then writes the buffer back to erasable memory, with a freshly computed odd-parity bit. Fixed memory is read only; its write-back pulse passes without a write strobe, and the cycle timing stays the same.

The word read from memory is checked for odd parity on the pulse where it first becomes valid in the buffer. This is pulse 6 for erasable memory and pulse 7 for fixed memory. A word with an even count of ones sets a sticky alarm, which stays set until the clear input is asserted. Every word has the parity bit in bit 15 and the data in bits 14:0. The memory array and any bank mapping are outside this block.

Top module: `cyc_mem_seq`

## Requirements
- R1: The output `tp` counts 1, 2, ..., 12 and then returns to 1, one step per clock, with no idle state. It shows 1 during and right after reset.
- R2: At the end of pulse 1, `req_addr` and `req_fixed` are captured. From pulse 2 until pulse 1 of the next cycle, they appear on `mem_addr` and `mem_fixed`.
- R3: `mem_rd_en` is high only during pulse 5 for erasable memory (`mem_fixed`=0) or pulse 6 for fixed memory. The word on `mem_rd_data` is loaded into the buffer at the end of that pulse, so `cpu_rdata` shows its bits 14:0 from pulse 6 (erasable) or pulse 7 (fixed).
- R4: `cpu_win` is high during pulses 7 through 10 and low on all other pulses. `cpu_rdata` always shows buffer bits 14:0.
- R5: When `cpu_we` is high during the window, `cpu_wdata` replaces the buffer data bits at the end of that pulse. A write on any other pulse is ignored and leaves the written-back word unchanged.
- R6: `mem_wr_en` is high only during pulse 11, and only when `mem_fixed`=0. A cycle on fixed memory produces no write strobe.
- R7: During write-back, `mem_wr_data` carries the buffer data bits in bits 14:0. Bit 15 is recomputed so that the count of ones in the 16-bit word is odd.
- R8: At the end of pulse 6 (erasable) or pulse 7 (fixed), a buffered word whose 16 bits hold an even count of ones sets `parity_alarm`.
- R9: `parity_alarm` stays set until `alarm_clr` is high at a clock edge. If a clear and a new parity error occur on the same pulse, the alarm stays set.
- R10: While `rst_n` is low, `parity_alarm`, `cpu_win` and `mem_wr_en` are 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timing pulse per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | ADDR_W | Address requested for the next cycle, sampled on pulse 1 |
| req_fixed | input | 1 | 1 = requested address is fixed memory, sampled on pulse 1 |
| tp | output | 4 | Current timing pulse number, 1 to 12 |
| mem_addr | output | ADDR_W | Latched memory address |
| mem_fixed | output | 1 | Latched memory type flag |
| mem_rd_en | output | 1 | Read strobe to memory |
| mem_rd_data | input | 16 | Word returned by memory: parity in bit 15, data in bits 14:0 |
| mem_wr_en | output | 1 | Write-back strobe to erasable memory |
| mem_wr_data | output | 16 | Write-back word with regenerated parity |
| cpu_win | output | 1 | Processor access window, pulses 7 to 10 |
| cpu_rdata | output | 15 | Buffer data bits |
| cpu_we | input | 1 | Processor write request |
| cpu_wdata | input | 15 | Processor write data |
| alarm_clr | input | 1 | Clears the parity alarm |
| parity_alarm | output | 1 | Sticky parity alarm |

## Verification
A pulse counter that slips shows up within one cycle: the read strobe, the window or the write strobe moves to the wrong pulse number on `tp`. A corrupted buffer or address register shows up by pulse 11 of the same cycle as a wrong `mem_wr_data` or a write to the wrong location. The next read of that location then repeats the error. A wrong alarm state is visible on `parity_alarm` one pulse after the check pulse, or one pulse after a clear. The bench sweeps every location of a small erasable and fixed space twice. It uses planted parity errors and window writes on all four pulses. It also tries writes outside the window and clears that collide with an error.

// File: rtl/cms_pkg.sv
// Package: shared widths, pulse numbers and the parity helper for the
// cyclic memory sequencer. Assumes pulses are numbered from 1.
package cms_pkg;
    localparam int DATA_W = 15;
    localparam int WORD_W = DATA_W + 1;
    localparam int NUM_TP = 12;
    localparam int TP_W   = $clog2(NUM_TP + 1);

    localparam logic [TP_W-1:0] TP_ADDR      = TP_W'(1);
    localparam logic [TP_W-1:0] TP_RD_ERAS   = TP_W'(5);
    localparam logic [TP_W-1:0] TP_RD_FIX    = TP_W'(6);
    localparam logic [TP_W-1:0] TP_CHK_ERAS  = TP_RD_ERAS + TP_W'(1);
    localparam logic [TP_W-1:0] TP_CHK_FIX   = TP_RD_FIX + TP_W'(1);
    localparam logic [TP_W-1:0] TP_WIN_FIRST = TP_W'(7);
    localparam logic [TP_W-1:0] TP_WIN_LAST  = TP_W'(10);
    localparam logic [TP_W-1:0] TP_WB        = TP_WIN_LAST + TP_W'(1);
    localparam logic [TP_W-1:0] TP_LAST      = TP_W'(NUM_TP);

    // Parity bit that makes the total count of ones odd.
    function automatic logic odd_par(input logic [DATA_W-1:0] d);
        return ~(^d);
    endfunction
endpackage

// File: rtl/cms_pulse_gen.sv
// Timing pulse generator: counts 1..NUM_TP forever.
// Assumes: synchronous active-low reset; reset value is pulse 1.
module cms_pulse_gen
    import cms_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [TP_W-1:0] tp
);
    // Advance the pulse number, wrapping from the last pulse to the first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tp <= TP_ADDR;
        else if (tp == TP_LAST)
            tp <= TP_ADDR;
        else
            tp <= tp + TP_W'(1);
    end
endmodule

// File: rtl/cms_addr_reg.sv
// Address register: holds the address and memory type for one cycle.
// Assumes: load is a single-pulse strobe from the sequencer.
module cms_addr_reg #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fixed,
    output logic [ADDR_W-1:0] addr_q,
    output logic              fixed_q
);
    // Capture the request on the load pulse, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            fixed_q <= 1'b0;
        end else if (load) begin
            addr_q  <= req_addr;
            fixed_q <= req_fixed;
        end
    end
endmodule

// File: rtl/cms_word_buf.sv
// Buffer register: loaded from memory on the read strobe. Data bits can be
// overwritten by the processor when the write is qualified. The write-back
// word with fresh parity is produced here. Assumes rd_strobe and wr_ok are
// never high together.
module cms_word_buf
    import cms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WORD_W-1:0] buf_q,
    output logic [WORD_W-1:0] wb_word
);
    // Load from memory, or take processor data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_q <= '0;
        else if (rd_strobe)
            buf_q <= rd_word;
        else if (wr_ok)
            buf_q[DATA_W-1:0] <= wr_data;
    end

    // Regenerate parity from the data bits for write-back.
    always_comb begin
        wb_word = {odd_par(buf_q[DATA_W-1:0]), buf_q[DATA_W-1:0]};
    end
endmodule

// File: rtl/cms_par_alarm.sv
// Parity checker with sticky alarm. Assumes chk_en is high for one pulse
// per cycle, when the buffer holds a freshly read word.
module cms_par_alarm
    import cms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic [WORD_W-1:0] word,
    input  logic              clr,
    output logic              alarm
);
    logic par_err;

    // Even count of ones is an error.
    always_comb begin
        par_err = chk_en && !(^word);
    end

    // A new error wins over a clear; otherwise the alarm holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm <= 1'b0;
        else
            alarm <= par_err | (alarm & ~clr);
    end
endmodule

// File: rtl/cyc_mem_seq.sv
// Cyclic memory sequencer top. It runs a 12-pulse cycle: address latch,
// read into the buffer, processor window, then write-back to erasable
// memory. Assumes memory returns read data in the same pulse as mem_rd_en.
module cyc_mem_seq
    import cms_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fixed,
    output logic [TP_W-1:0]   tp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_fixed,
    output logic              mem_rd_en,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              cpu_win,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              alarm_clr,
    output logic              parity_alarm
);
    logic              load_addr;
    logic              chk_en;
    logic              wr_ok;
    logic [WORD_W-1:0] buf_q;

    cms_pulse_gen u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .tp    (tp)
    );

    // Decode per-pulse strobes from the pulse number and memory type.
    always_comb begin
        load_addr = (tp == TP_ADDR);
        mem_rd_en = mem_fixed ? (tp == TP_RD_FIX) : (tp == TP_RD_ERAS);
        chk_en    = mem_fixed ? (tp == TP_CHK_FIX) : (tp == TP_CHK_ERAS);
        cpu_win   = (tp >= TP_WIN_FIRST) && (tp <= TP_WIN_LAST);
        wr_ok     = cpu_win && cpu_we;
        mem_wr_en = (tp == TP_WB) && !mem_fixed;
        cpu_rdata = buf_q[DATA_W-1:0];
    end

    cms_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_addr),
        .req_addr  (req_addr),
        .req_fixed (req_fixed),
        .addr_q    (mem_addr),
        .fixed_q   (mem_fixed)
    );

    cms_word_buf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (mem_rd_en),
        .rd_word   (mem_rd_data),
        .wr_ok     (wr_ok),
        .wr_data   (cpu_wdata),
        .buf_q     (buf_q),
        .wb_word   (mem_wr_data)
    );

    cms_par_alarm u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .chk_en(chk_en),
        .word  (buf_q),
        .clr   (alarm_clr),
        .alarm (parity_alarm)
    );
endmodule

// File: rtl/cyc_mem_seq_chk.sv
// Checker for cyc_mem_seq: port-level timing properties, bound to the top.
module cyc_mem_seq_chk
    import cms_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] req_addr,
    input logic [TP_W-1:0]   tp,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_fixed,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [WORD_W-1:0] mem_wr_data,
    input logic              cpu_win,
    input logic              alarm_clr,
    input logic              parity_alarm
);
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tp == TP_LAST |=> tp == TP_ADDR);
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        tp != TP_LAST |=> tp == $past(tp) + TP_W'(1));
    a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        tp == TP_ADDR |=> mem_addr == $past(req_addr));
    a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_fixed ? tp == TP_RD_FIX : tp == TP_RD_ERAS));
    a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_win |-> (tp >= TP_WIN_FIRST && tp <= TP_WIN_LAST));
    a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (tp == TP_WB && !mem_fixed));
    a_r7_wr_parity: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ^mem_wr_data);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        parity_alarm && !alarm_clr |=> parity_alarm);
    a_r8_set_only_on_check: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_alarm && !(mem_fixed ? tp == TP_CHK_FIX : tp == TP_CHK_ERAS)
        |=> !parity_alarm);
endmodule

bind cyc_mem_seq cyc_mem_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_addr    (req_addr),
    .tp          (tp),
    .mem_addr    (mem_addr),
    .mem_fixed   (mem_fixed),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_data (mem_wr_data),
    .cpu_win     (cpu_win),
    .alarm_clr   (alarm_clr),
    .parity_alarm(parity_alarm)
);

// File: tb/cyc_mem_seq_tb_top.sv
// Bench: sweeps every location of a 16-word erasable and fixed space twice,
// with a behavioural memory and an arithmetic expected model.
module cyc_mem_seq_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_fixed = 1'b0;
    logic [3:0]    tp;
    logic [AW-1:0] mem_addr;
    logic          mem_fixed;
    logic          mem_rd_en;
    logic [15:0]   mem_rd_data;
    logic          mem_wr_en;
    logic [15:0]   mem_wr_data;
    logic          cpu_win;
    logic [14:0]   cpu_rdata;
    logic          cpu_we = 1'b0;
    logic [14:0]   cpu_wdata = '0;
    logic          alarm_clr = 1'b0;
    logic          parity_alarm;

    logic [15:0]   eram [16];
    logic [15:0]   fram [16];
    int            checks = 0;
    int            errors = 0;
    logic          exp_alarm = 1'b0;
    logic          done = 1'b0;

    always #5 clk = ~clk;

    cyc_mem_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_fixed(req_fixed),
        .tp(tp), .mem_addr(mem_addr), .mem_fixed(mem_fixed),
        .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
        .cpu_win(cpu_win), .cpu_rdata(cpu_rdata), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .alarm_clr(alarm_clr),
        .parity_alarm(parity_alarm)
    );

    assign mem_rd_data = mem_fixed ? fram[mem_addr[3:0]] : eram[mem_addr[3:0]];

    always @(posedge clk) begin
        if (mem_wr_en) eram[mem_addr[3:0]] <= mem_wr_data;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One full cycle; wp = pulse of processor write (0 = none), clrp = clear pulse.
    task automatic run_cycle(input logic [3:0] a, input logic fx, input int wp,
                             input logic [14:0] wv, input int clrp);
        logic [15:0] word = '0;
        logic        bad = 1'b0;
        logic [14:0] expd = '0;
        logic        nxt;
        logic [AW-1:0] ra = {a, ~a, a};
        int          chkp = fx ? 7 : 6;
        for (int p = 1; p <= 12; p++) begin
            chk(tp == 4'(p), "R1 pulse", int'(tp), p);
            if (p == 1) begin
                req_addr  = ra;
                req_fixed = fx;
            end
            if (p == 2) begin
                chk(mem_addr == ra && mem_fixed == fx, "R2 addr", int'(mem_addr), int'(ra));
                word = fx ? fram[a] : eram[a];
                bad  = ~(^word);
                expd = (wp >= 7 && wp <= 10) ? wv : word[14:0];
            end
            chk(mem_rd_en == ((p == 5 && !fx) || (p == 6 && fx)), "R3 rd strobe",
                int'(mem_rd_en), p);
            if (p == chkp)
                chk(cpu_rdata == word[14:0], "R3 buffer load", int'(cpu_rdata), int'(word[14:0]));
            chk(cpu_win == (p >= 7 && p <= 10), "R4 window", int'(cpu_win), p);
            if (p == 11) begin
                chk(mem_wr_en == !fx, "R6 wb strobe", int'(mem_wr_en), int'(!fx));
                if (!fx)
                    chk(mem_wr_data == {~(^expd), expd}, "R5 R7 wb data",
                        int'(mem_wr_data), int'({~(^expd), expd}));
            end else begin
                chk(mem_wr_en == 1'b0, "R6 no wb", int'(mem_wr_en), 0);
            end
            chk(parity_alarm == exp_alarm, "R8 R9 alarm", int'(parity_alarm), int'(exp_alarm));
            cpu_we    = (p == wp);
            cpu_wdata = wv;
            alarm_clr = (p == clrp);
            nxt = exp_alarm;
            if (p == clrp) nxt = 1'b0;
            if (p == chkp && bad) nxt = 1'b1;
            @(negedge clk);
            exp_alarm = nxt;
        end
        cpu_we    = 1'b0;
        alarm_clr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            logic [14:0] de = 15'(i * 1234 + 77);
            logic [14:0] df = 15'(i * 2011 + 5);
            eram[i] = {(i == 3 || i == 9) ? ^de : ~(^de), de};
            fram[i] = {(i == 5) ? ^df : ~(^df), df};
        end
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(tp == 4'd1, "R10 R1 reset pulse", int'(tp), 1);
        chk(parity_alarm == 1'b0, "R10 alarm", int'(parity_alarm), 0);
        chk(cpu_win == 1'b0, "R10 window", int'(cpu_win), 0);
        chk(mem_wr_en == 1'b0, "R10 wb", int'(mem_wr_en), 0);
        chk(mem_addr == '0, "R10 addr", int'(mem_addr), 0);
        rst_n = 1'b1;
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 16; a++) begin
                for (int f = 0; f < 2; f++) begin
                    int sel = (a + pass) % 6;
                    int wp  = (sel == 0) ? 0 : (sel == 5) ? ((a % 2 == 0) ? 6 : 2) : sel + 6;
                    int clrp = (a % 4 == 3) ? 12 : ((a == 9 && f == 0) ? 6 : 0);
                    run_cycle(4'(a), f[0], wp, 15'(a * 977 + f * 3 + pass * 31 + 1), clrp);
                end
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule